// File: doc/BRIEF.md
# Shifted-Offset Load Address Generator

This block forms effective addresses for a family of element loads whose immediate displacement is scaled before it reaches the adder. The sign-extended displacement is shifted left by an amount read from a register, and in stride mode it is first multiplied by a bit-reversed element counter. Stride mode walks the butterfly access order of a radix-2 FFT. The block also turns the bytes that memory returns into a 64-bit register value, either zero-filled or sign-filled. When an update form is selected, it offers the new address as a write-back value for the base register.

One request is accepted per cycle on `req_valid`, with the memory data for that element already present on `mem_data`. All results appear registered one cycle later and are qualified by `out_valid`. In stride mode, a `start` pulse clears the element counter. Each accepted request then uses the current counter value and moves the counter forward, wrapping modulo the vector length. `done` is raised together with the result of the last element.

Top module: `olag_top`

## Requirements
- R1: After reset `out_valid`, `wb_en` and `done` are 0. Every accepted request produces exactly one result with `out_valid` high in the following cycle.
- R2: The shift amount is bits [5:0] of `shift_ctl` (0 to 63). Bits [63:6] have no effect on the address.
- R3: With `rev_mode`=0, `ea` = base + (sign-extended displacement << shift), taken modulo 2^64.
- R4: With `rev_mode`=1, the sign-extended displacement is multiplied by the bit-reversed element index before the shift. The index is the element counter with its low `vl_log2` bits mirrored. VL = 2^`vl_log2` (1 to 64; values above 6 act as 6), and VL=1 gives index 0.
- R5: A `start` pulse sets the element counter to 0. Each request accepted with `rev_mode`=1 advances the counter by one modulo VL.
- R6: `done` is 1 exactly on the result of a stride-mode element whose counter value was VL-1.
- R7: With `upd_form`=0 and `base_is_r0`=1, the base is 0. In every other case the base is `base_val`.
- R8: With `upd_form`=1, `wb_en` is 1 and `wb_val` equals `ea`. With `upd_form`=0, `wb_en` is 0.
- R9: With `ds_form`=1, the displacement is `disp[DISP_W-3:0]` with two zero bits appended below it, then sign-extended. The top two `disp` bits are ignored.
- R10: `acc_size` selects 0=byte, 1=halfword, 2=word, 3=doubleword. The value is taken from the low bytes of `mem_data`. Byte, halfword and word loads fill the upper 56, 48 or 32 bits with zeros.
- R11: With `sign_ext`=1, halfword and word loads copy bit 15 or bit 31 into all higher bits. Byte and doubleword results ignore `sign_ext`, and a doubleword passes `mem_data` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the stride element counter |
| req_valid | input | 1 | Element request accepted this cycle |
| rev_mode | input | 1 | 1: bit-reversed stride scaling |
| vl_log2 | input | 3 | log2 of the vector length |
| base_val | input | 64 | Base register contents |
| base_is_r0 | input | 1 | Base register number is zero |
| upd_form | input | 1 | Update form: write the address back |
| disp | input | DISP_W | Immediate displacement |
| ds_form | input | 1 | Displacement has two implied low zero bits |
| shift_ctl | input | 64 | Shift-control register |
| acc_size | input | 2 | Access size code |
| sign_ext | input | 1 | Algebraic (sign-extending) load |
| mem_data | input | 64 | Right-aligned memory data for the element |
| out_valid | output | 1 | Result valid |
| ea | output | 64 | Effective address |
| wb_en | output | 1 | Base register write-back enable |
| wb_val | output | 64 | Base register write-back value |
| ld_result | output | 64 | Extended load result |
| done | output | 1 | Last stride element issued |

## Verification
The hardest situations to reach are the wrap of the element counter and the terminal `done` for each vector length. Both depend on a run of requests that have to follow a `start` pulse. The stimulus runs a full pass for every `vl_log2` from 0 to 6, so each bit-reversal width is used and every element's address is compared. It also puts junk in the upper bits of `shift_ctl` and of a `ds_form` displacement, so that bits the block must ignore would change the address if they leaked.

// File: rtl/olag_pkg.sv
package olag_pkg;

  localparam int unsigned XLEN    = 64;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned MAX_LG  = 6;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // mirror the low lg bits of step; higher bits come out zero
  function automatic logic [IDX_W-1:0] mirror_index(input logic [IDX_W-1:0] step,
                                                    input logic [2:0] lg);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < IDX_W; i++) begin
      if (i < int'(lg)) r[i] = step[int'(lg) - 1 - i];
    end
    return r;
  endfunction

  function automatic logic [XLEN-1:0] shape_load(input logic [XLEN-1:0] raw,
                                                 input acc_size_e sz,
                                                 input logic sx);
    logic [XLEN-1:0] r;
    unique case (sz)
      SZ_BYTE:  r = {56'd0, raw[7:0]};
      SZ_HALF:  r = sx ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
      SZ_WORD:  r = sx ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
      default:  r = raw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/olag_step.sv
module olag_step
  import olag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adv,
  input  logic [2:0]       lg,
  output logic [IDX_W-1:0] cur_step,
  output logic             at_last
);
  localparam int unsigned SPAN = IDX_W + 1;

  logic [IDX_W-1:0] step_q;
  logic [IDX_W-1:0] wrap_mask;

  assign wrap_mask = IDX_W'((SPAN'(1) << lg) - SPAN'(1));
  assign cur_step  = start ? '0 : step_q;
  assign at_last   = (cur_step == wrap_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   step_q <= '0;
    else if (adv) step_q <= (cur_step + IDX_W'(1)) & wrap_mask;
    else if (start) step_q <= '0;
  end
endmodule

// File: rtl/olag_addr.sv
module olag_addr
  import olag_pkg::*;
#(
  parameter int unsigned DISP_W = 16
) (
  input  logic [XLEN-1:0]   base_val,
  input  logic              base_zero,
  input  logic [DISP_W-1:0] disp,
  input  logic              ds_form,
  input  logic [XLEN-1:0]   shift_ctl,
  input  logic [IDX_W-1:0]  scale,
  output logic [XLEN-1:0]   ea
);
  localparam int unsigned SH_W = $clog2(XLEN);

  logic [DISP_W-1:0] disp_fmt;
  logic [XLEN-1:0]   disp_sx;
  logic [XLEN-1:0]   scaled;
  logic [SH_W-1:0]   sh_amt;
  logic [XLEN-1:0]   base_eff;

  generate
    if (DISP_W > 2) begin : g_ds
      assign disp_fmt = ds_form ? {disp[DISP_W-3:0], 2'b00} : disp;
    end else begin : g_plain
      assign disp_fmt = ds_form ? '0 : disp;
    end
  endgenerate

  assign disp_sx  = {{(XLEN-DISP_W){disp_fmt[DISP_W-1]}}, disp_fmt};
  assign scaled   = disp_sx * {{(XLEN-IDX_W){1'b0}}, scale};
  assign sh_amt   = shift_ctl[SH_W-1:0];
  assign base_eff = base_zero ? '0 : base_val;
  assign ea       = base_eff + (scaled << sh_amt);
endmodule

// File: rtl/olag_top.sv
module olag_top
  import olag_pkg::*;
#(
  parameter int unsigned DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_valid,
  input  logic              rev_mode,
  input  logic [2:0]        vl_log2,
  input  logic [63:0]       base_val,
  input  logic              base_is_r0,
  input  logic              upd_form,
  input  logic [DISP_W-1:0] disp,
  input  logic              ds_form,
  input  logic [63:0]       shift_ctl,
  input  logic [1:0]        acc_size,
  input  logic              sign_ext,
  input  logic [63:0]       mem_data,
  output logic              out_valid,
  output logic [63:0]       ea,
  output logic              wb_en,
  output logic [63:0]       wb_val,
  output logic [63:0]       ld_result,
  output logic              done
);
  // named internal events, observed by the checker
  logic [2:0]       lg_eff;
  logic [IDX_W-1:0] step_now;
  logic             step_last;
  logic             step_adv;
  logic [IDX_W-1:0] scale_idx;
  logic             base_zero;
  logic [XLEN-1:0]  ea_comb;
  logic [XLEN-1:0]  res_comb;

  assign lg_eff    = (vl_log2 > 3'(MAX_LG)) ? 3'(MAX_LG) : vl_log2;
  assign step_adv  = req_valid && rev_mode;
  assign base_zero = base_is_r0 && !upd_form;
  assign scale_idx = rev_mode ? mirror_index(step_now, lg_eff) : IDX_W'(1);

  olag_step u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .adv      (step_adv),
    .lg       (lg_eff),
    .cur_step (step_now),
    .at_last  (step_last)
  );

  olag_addr #(.DISP_W(DISP_W)) u_addr (
    .base_val  (base_val),
    .base_zero (base_zero),
    .disp      (disp),
    .ds_form   (ds_form),
    .shift_ctl (shift_ctl),
    .scale     (scale_idx),
    .ea        (ea_comb)
  );

  assign res_comb = shape_load(mem_data, acc_size_e'(acc_size), sign_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      done      <= 1'b0;
      ea        <= '0;
      wb_val    <= '0;
      ld_result <= '0;
    end else begin
      out_valid <= req_valid;
      wb_en     <= req_valid && upd_form;
      done      <= step_adv && step_last;
      if (req_valid) begin
        ea        <= ea_comb;
        wb_val    <= ea_comb;
        ld_result <= res_comb;
      end
    end
  end
endmodule

// File: rtl/olag_chk.sv
module olag_chk
  import olag_pkg::*;
#(
  parameter int unsigned DISP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              req_valid,
  input logic              rev_mode,
  input logic              upd_form,
  input logic              base_is_r0,
  input logic [DISP_W-1:0] disp,
  input logic [1:0]        acc_size,
  input logic [2:0]        lg_eff,
  input logic [IDX_W-1:0]  step_now,
  input logic              out_valid,
  input logic              wb_en,
  input logic [63:0]       ea,
  input logic [63:0]       ld_result,
  input logic              done
);
  logic [IDX_W-1:0] chk_mask;
  assign chk_mask = IDX_W'((7'd1 << lg_eff) - 7'd1);

  // R1
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R5
  start_clears_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(req_valid && rev_mode)) |=> (step_now == '0) || start);

  // R5
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rev_mode && !$isunknown(step_now)) |=>
      (start || step_now == ((($past(step_now) + IDX_W'(1))) & $past(chk_mask))));

  // R6
  done_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  // R8
  wb_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid);

  // R7
  zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && base_is_r0 && !upd_form && disp == '0) |=> (ea == 64'd0));

  // R10
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_size == 2'd0) |=> (ld_result[63:8] == 56'd0));
endmodule

bind olag_top olag_chk #(.DISP_W(DISP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .req_valid  (req_valid),
  .rev_mode   (rev_mode),
  .upd_form   (upd_form),
  .base_is_r0 (base_is_r0),
  .disp       (disp),
  .acc_size   (acc_size),
  .lg_eff     (lg_eff),
  .step_now   (step_now),
  .out_valid  (out_valid),
  .wb_en      (wb_en),
  .ea         (ea),
  .ld_result  (ld_result),
  .done       (done)
);

// File: tb/olag_top_test.sv
module olag_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_valid = 1'b0;
  logic        rev_mode = 1'b0;
  logic [2:0]  vl_log2 = 3'd0;
  logic [63:0] base_val = '0;
  logic        base_is_r0 = 1'b0;
  logic        upd_form = 1'b0;
  logic [15:0] disp = '0;
  logic        ds_form = 1'b0;
  logic [63:0] shift_ctl = '0;
  logic [1:0]  acc_size = 2'd0;
  logic        sign_ext = 1'b0;
  logic [63:0] mem_data = '0;
  logic        out_valid, wb_en, done;
  logic [63:0] ea, wb_val, ld_result;

  int n_checks = 0;
  int n_fails  = 0;
  int model_step = 0;
  int pending = 0;

  typedef struct {
    logic [63:0] ea;
    logic        wb;
    logic [63:0] res;
    logic        dn;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  olag_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
    .rev_mode(rev_mode), .vl_log2(vl_log2), .base_val(base_val),
    .base_is_r0(base_is_r0), .upd_form(upd_form), .disp(disp),
    .ds_form(ds_form), .shift_ctl(shift_ctl), .acc_size(acc_size),
    .sign_ext(sign_ext), .mem_data(mem_data), .out_valid(out_valid),
    .ea(ea), .wb_en(wb_en), .wb_val(wb_val), .ld_result(ld_result),
    .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic longint unsigned ref_rev(input int s, input int lg);
    longint unsigned r = 0;
    for (int k = 0; k < lg; k++) r = (r << 1) | longint'((s >> k) & 1);
    return r;
  endfunction

  // issue one element; expected values from the requirements
  task automatic issue(input bit rv, input int lg, input logic [63:0] b, input bit r0,
                       input bit up, input logic [15:0] d, input bit ds,
                       input logic [63:0] sc, input int sz, input bit sx,
                       input logic [63:0] md, input string tag);
    exp_t e;
    longint dv;
    longint unsigned mul, bse, pw;
    int lge;
    lge = (lg > 6) ? 6 : lg;
    if (ds) dv = longint'($signed(d[13:0])) * 4;   // R9
    else    dv = longint'($signed(d));
    mul = rv ? ref_rev(model_step, lge) : 64'd1;   // R4
    pw  = 64'd1 << sc[5:0];                        // R2
    bse = (r0 && !up) ? 64'd0 : b;                 // R7
    e.ea  = bse + longint'(dv) * mul * pw;         // R3
    e.wb  = up;
    case (sz)
      0: e.res = md & 64'hFF;
      1: e.res = sx ? 64'(longint'($signed(md[15:0]))) : (md & 64'hFFFF);
      2: e.res = sx ? 64'(longint'($signed(md[31:0]))) : (md & 64'hFFFF_FFFF);
      default: e.res = md;
    endcase
    e.dn  = rv && (model_step == (1 << lge) - 1);  // R6
    e.tag = tag;
    if (rv) model_step = (model_step + 1) % (1 << lge);
    sb.push_back(e);
    pending++;
    rev_mode = rv; vl_log2 = 3'(lg); base_val = b; base_is_r0 = r0;
    upd_form = up; disp = d; ds_form = ds; shift_ctl = sc;
    acc_size = 2'(sz); sign_ext = sx; mem_data = md; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1; model_step = 0;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) check(1'b0, "R1 unexpected result", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        pending--;
        check(ea === e.ea, {e.tag, " ea"}, ea, e.ea);
        check(wb_en === e.wb, {"R8 wb_en ", e.tag}, 64'(wb_en), 64'(e.wb));
        if (e.wb) check(wb_val === e.ea, {"R8 wb_val ", e.tag}, wb_val, e.ea);
        check(ld_result === e.res, {e.tag, " result"}, ld_result, e.res);
        check(done === e.dn, {"R6 done ", e.tag}, 64'(done), 64'(e.dn));
      end
    end else if (rst_n) begin
      if (done !== 1'b0) check(1'b0, "R6 done without result", 64'(done), 64'd0);
    end
  end

  initial begin
    #2000000;
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #35;
    check(out_valid === 1'b0 && wb_en === 1'b0 && done === 1'b0, "R1 reset state",
          {61'd0, out_valid, wb_en, done}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // shifted mode, R3 / R10 / R11
    issue(0, 0, 64'h1000, 0, 0, 16'h0010, 0, 64'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FF81, "R3 n0 byte R10");
    issue(0, 0, 64'h1000, 0, 0, 16'hFFF0, 0, 64'd4, 1, 1, 64'h0000_0000_0000_8001, "R3 neg R11 half");
    issue(0, 0, 64'h1000, 0, 0, 16'h0001, 0, 64'd63, 1, 0, 64'h0000_0000_0000_8001, "R3 n63 R10 half");
    issue(0, 0, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 16'h0020, 0, 64'd0, 2, 1, 64'h0000_0000_8000_0000, "R3 wrap R11 word");
    issue(0, 0, 64'h55, 0, 0, 16'h8000, 0, 64'd3, 2, 0, 64'hAAAA_AAAA_8000_0000, "R3 minneg R10 word");
    issue(0, 0, 64'h0, 0, 0, 16'h0002, 0, 64'd2, 3, 1, 64'hDEAD_BEEF_0123_4567, "R11 dword");
    issue(0, 0, 64'h0, 0, 0, 16'h0002, 0, 64'd0, 0, 1, 64'h0000_0000_0000_00F0, "R11 byte sx ignored");
    // R2 upper shift bits ignored
    issue(0, 0, 64'h100, 0, 0, 16'h0003, 0, 64'hFFFF_FFFF_FFFF_FFC5, 3, 0, 64'h1, "R2 upper bits");
    // R7 base register zero
    issue(0, 0, 64'h1234_5678, 1, 0, 16'h0040, 0, 64'd1, 0, 0, 64'h12, "R7 r0 nonupdate");
    issue(0, 0, 64'h1234_5678, 1, 1, 16'hFFFC, 0, 64'd1, 0, 0, 64'h12, "R7 R8 r0 update");
    issue(0, 0, 64'h8000, 0, 1, 16'h0100, 0, 64'd5, 1, 0, 64'h7FFF, "R8 update");
    // R9 ds form, junk in the two ignored top bits
    issue(0, 0, 64'h2000, 0, 0, 16'hC005, 1, 64'd0, 3, 0, 64'h9, "R9 ds junk top");
    issue(0, 0, 64'h2000, 0, 0, 16'h2000, 1, 64'd1, 2, 1, 64'hFFFF_FFFF, "R9 ds negative");

    // R4 / R5 / R6: every vector length
    for (int lg = 0; lg <= 7; lg++) begin
      pulse_start();
      for (int k = 0; k < (1 << ((lg > 6) ? 6 : lg)); k++)
        issue(1, lg, 64'h4_0000, 0, (k % 3) == 0, 16'hFFF8 + 16'(k % 5), 0,
              64'hABCD_0000_0000_0040 | 64'(k % 4), 3, 0, 64'(k), "R4 R5 stride");
    end
    // R5 wrap: continue past VL without start
    pulse_start();
    for (int k = 0; k < 6; k++)
      issue(1, 2, 64'h0, 1, 0, 16'h0001, 0, 64'd0, 0, 0, 64'h0, "R5 wrap");
    // R5 start mid-vector restarts at 0
    pulse_start();
    issue(1, 3, 64'h0, 1, 0, 16'h0001, 0, 64'd0, 0, 0, 64'h0, "R5 partial");
    issue(1, 3, 64'h0, 1, 0, 16'h0001, 0, 64'd0, 0, 0, 64'h0, "R5 partial");
    pulse_start();
    for (int k = 0; k < 8; k++)
      issue(1, 3, 64'h10, 0, 0, 16'h0003, 1, 64'd2, 1, 1, 64'hFF80, "R5 restart R9");

    repeat (4) @(posedge clk);
    check(pending == 0, "R1 all results seen", 64'(pending), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule